// File: doc/BRIEF.md
# Supply-Loss Write Guard Sequencer

This block sits beside a battery-backed static memory and decides, from three supply-level flags, when the memory may be accessed. The flags come from external comparators. One reports that the main supply is present above the switchover level. One reports that it is above the protect level. One reports that it is above the full operating level. Each flag is synchronised and deglitched. The filtered levels drive a small state machine with five states: factory-fresh, on battery, protected, recovering, and running.

The outputs are control levels for the memory interface. `wr_protect` gates off every access and isolates the data bus. `bat_select` chooses the backup cell as the memory supply. `ready` tells the host that accesses are accepted. A sticky `armed` bit records that the backup cell has been enabled. It is cleared only by the dedicated factory input and not by the ordinary reset. Until the main supply has first appeared, the backup cell is never selected.

Top module: `pwr_guard_seq`

## Requirements
- R1: While `factory_clr` is high and for the cycle after it is released, `wr_protect`=1, `bat_select`=0, `ready`=0 and `armed`=0.
- R2: While `armed`=0, `bat_select` is 0 whatever the flags do.
- R3: `armed` becomes 1 at the same edge on which the filtered main flag first moves the machine out of the fresh state. It stays 1 through any ordinary reset and is cleared only by `factory_clr`=1.
- R4: Once armed, the filtered main flag going low selects the battery (`bat_select`=1), taking priority over every other flag. The filtered main flag going high deselects it (`bat_select`=0).
- R5: The filtered guard flag going low forces `wr_protect`=1 and `ready`=0 on the next edge.
- R6: Recovery starts from the protected state when both the guard and run flags are high. `ready` rises exactly `REC_CYCLES` clock edges after recovery is entered. `ready` is always the inverse of `wr_protect`.
- R7: If the guard flag drops during recovery, the machine returns to protected and the recovery count restarts from zero the next time recovery is entered.
- R8: A flag change that lasts fewer than `FILT_LEN` consecutive synchronised samples has no effect. A change held for `FILT_LEN` samples is accepted.
- R9: While running, the run flag falling while the guard flag stays high leaves `ready`=1.
- R10: In the protected state with the guard flag high but the run flag low, `wr_protect` stays 1.
- R11: An ordinary reset with `armed`=1 restarts the machine on battery (`bat_select`=1) until the filtered main flag is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary synchronous reset, active low; keeps `armed` |
| factory_clr | input | 1 | Synchronous factory reset, active high; clears `armed` |
| vmain_ok | input | 1 | Supply above the switchover level (asynchronous) |
| vguard_ok | input | 1 | Supply above the protect level (asynchronous) |
| vrun_ok | input | 1 | Supply above the full operating level (asynchronous) |
| wr_protect | output | 1 | 1 = accesses blocked, data bus isolated |
| bat_select | output | 1 | 1 = memory supplied from the backup cell |
| ready | output | 1 | 1 = accesses accepted |
| armed | output | 1 | Sticky: backup cell switchover enabled |

## Verification
A flag change driven mid-cycle passes two synchroniser flops and `FILT_LEN` filter samples. It therefore reaches the state, and with it every output, on the `FILT_LEN+3`-th edge after the change. `ready` then follows `REC_CYCLES` edges after recovery is entered. The bench samples each output at mid-cycle, one edge before its due edge and again just after it, so a result that is early or late is caught as well as a wrong value. The deglitch boundary is swept over pulse lengths from one sample up to `FILT_LEN`. The recovery restart is timed from the moment the guard flag is raised again.

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int FILT_LEN   = 8,
  parameter int REC_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_clr,
  input  logic vmain_ok,
  input  logic vguard_ok,
  input  logic vrun_ok,
  output logic wr_protect,
  output logic bat_select,
  output logic ready,
  output logic armed
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam int RW = $clog2(REC_CYCLES + 1);
  localparam int M = 0, G = 1, R = 2;

  typedef enum logic [2:0] {ST_FRESH, ST_BATT, ST_PROT, ST_RECOV, ST_RUN} st_t;

  logic [2:0] s1, s2, flt;
  logic [FW-1:0] fcnt [3];
  logic [RW-1:0] rcnt;
  logic armed_q;
  st_t st, nx;

  wire clr = !rst_n || factory_clr;

  always_ff @(posedge clk) begin
    if (clr) begin
      s1 <= '0;
      s2 <= '0;
      flt <= '0;
      for (int i = 0; i < 3; i++) fcnt[i] <= '0;
    end else begin
      s1 <= {vrun_ok, vguard_ok, vmain_ok};
      s2 <= s1;
      for (int i = 0; i < 3; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT_LEN - 1)) begin
          flt[i] <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    nx = st;
    case (st)
      ST_FRESH: if (flt[M]) nx = ST_PROT;
      ST_BATT:  if (flt[M]) nx = ST_PROT;
      ST_PROT:  if (!flt[M]) nx = ST_BATT;
                else if (flt[G] && flt[R]) nx = ST_RECOV;
      ST_RECOV: if (!flt[M]) nx = ST_BATT;
                else if (!flt[G]) nx = ST_PROT;
                else if (rcnt == RW'(REC_CYCLES - 1)) nx = ST_RUN;
      ST_RUN:   if (!flt[M]) nx = ST_BATT;
                else if (!flt[G]) nx = ST_PROT;
      default:  nx = ST_FRESH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (factory_clr) begin
      st <= ST_FRESH;
      armed_q <= 1'b0;
    end else if (!rst_n) begin
      st <= armed_q ? ST_BATT : ST_FRESH;
    end else begin
      st <= nx;
      if (st == ST_FRESH && flt[M]) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr || st != ST_RECOV) rcnt <= '0;
    else rcnt <= rcnt + 1'b1;
  end

  assign wr_protect = (st != ST_RUN);
  assign ready      = (st == ST_RUN);
  assign bat_select = (st == ST_BATT);
  assign armed      = armed_q;

  // R2
  fresh_isolated_chk: assert property (@(posedge clk) disable iff (clr)
    !armed_q |-> !bat_select);
  // R3
  armed_sticky_chk: assert property (@(posedge clk) disable iff (factory_clr)
    !$fell(armed_q));
  // R4
  main_loss_chk: assert property (@(posedge clk) disable iff (clr)
    ($fell(flt[M]) && armed_q) |=> bat_select);
  // R5
  guard_drop_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(flt[G]) |=> (wr_protect && !ready));
  // R6
  recov_len_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(ready) |-> ($past(st) == ST_RECOV && $past(rcnt) == RW'(REC_CYCLES - 1)));
  // R7
  recov_abort_chk: assert property (@(posedge clk) disable iff (clr)
    (st == ST_RECOV && !flt[G]) |=> !ready);
  // R8
  filt_src_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(flt[M]) |-> $past(s2[M]));
endmodule

// File: tb/sim_pwr_guard_seq.sv
module sim_pwr_guard_seq;
  localparam int FILT = 3;
  localparam int REC  = 12;
  localparam int LAT  = FILT + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, factory_clr = 1'b1;
  logic vm = 1'b0, vg = 1'b0, vr = 1'b0;
  logic wp, bs, rdy, arm;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pwr_guard_seq #(.FILT_LEN(FILT), .REC_CYCLES(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .factory_clr(factory_clr),
    .vmain_ok(vm), .vguard_ok(vg), .vrun_ok(vr),
    .wr_protect(wp), .bat_select(bs), .ready(rdy), .armed(arm));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #10;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 wp", wp, 1'b1); chk("R1 bat", bs, 1'b0);
    chk("R1 ready", rdy, 1'b0); chk("R1 armed", arm, 1'b0);
    factory_clr = 1'b0; rst_n = 1'b1;
    step(1);
    chk("R1 wp after", wp, 1'b1); chk("R1 armed after", arm, 1'b0);
    step(20);
    chk("R2 no battery when fresh", bs, 1'b0);

    // R8 short main pulses from fresh are ignored
    for (int p = 1; p < FILT; p++) begin
      vm = 1'b1; step(p); vm = 1'b0; step(2 * LAT);
      chk("R8 short pulse armed", arm, 1'b0);
      chk("R2 short pulse bat", bs, 1'b0);
    end

    // power-up
    vm = 1'b1; vg = 1'b1; vr = 1'b1;
    step(LAT - 1);
    chk("R3 not yet armed", arm, 1'b0);
    step(1);
    chk("R3 armed on exit", arm, 1'b1);
    chk("R2 bat after first power", bs, 1'b0);
    step(REC);
    chk("R6 ready not early", rdy, 1'b0);
    chk("R6 wp during recovery", wp, 1'b1);
    step(1);
    chk("R6 ready on time", rdy, 1'b1);
    chk("R6 wp inverse", wp, 1'b0);

    // R9 hysteresis band
    vr = 1'b0; step(2 * LAT);
    chk("R9 ready in band", rdy, 1'b1);

    // R5 guard loss
    vg = 1'b0; step(LAT - 1);
    chk("R5 wp not early", wp, 1'b0);
    step(1);
    chk("R5 wp set", wp, 1'b1); chk("R5 ready cleared", rdy, 1'b0);

    // R10 guard only
    vg = 1'b1; step(30);
    chk("R10 protected without run", wp, 1'b1);

    // R7 recovery restart
    vr = 1'b1; step(LAT + 1 + 2);
    vg = 1'b0; step(LAT);
    chk("R7 aborted", rdy, 1'b0);
    vg = 1'b1; step(LAT + REC - 1);
    chk("R7 restart not early", rdy, 1'b0);
    step(1);
    chk("R7 restart ready", rdy, 1'b1);

    // R4 supply loss from run
    vm = 1'b0; vg = 1'b0; vr = 1'b0;
    step(LAT - 1);
    chk("R4 bat not early", bs, 1'b0);
    step(1);
    chk("R4 on battery", bs, 1'b1);
    chk("R5 wp on battery", wp, 1'b1);
    chk("R5 ready on battery", rdy, 1'b0);

    // R8 boundary sweep on main while on battery
    for (int p = 1; p <= FILT; p++) begin
      vm = 1'b1; step(p); vm = 1'b0; step(LAT - p);
      chk("R8 boundary pulse", bs, (p >= FILT) ? 1'b0 : 1'b1);
      step(2 * LAT);
      chk("R4 back on battery", bs, 1'b1);
    end

    // R11 ordinary reset keeps armed, starts on battery
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    chk("R3 armed survives reset", arm, 1'b1);
    chk("R11 battery after reset", bs, 1'b1);

    // R4 return of main
    vm = 1'b1; step(LAT - 1);
    chk("R4 still battery", bs, 1'b1);
    step(1);
    chk("R4 main restored", bs, 1'b0);
    chk("R10 protected on main only", wp, 1'b1);

    // R3 factory clear
    factory_clr = 1'b1; step(2);
    chk("R3 factory clears armed", arm, 1'b0);
    chk("R1 factory bat", bs, 1'b0);
    factory_clr = 1'b0; vm = 1'b0; step(2 * LAT);
    chk("R2 fresh after factory", bs, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule